// File: doc/BRIEF.md
# Gapless Packet Stream Unpacker

The block receives a steady stream of fixed-width link frames, 80 or 112 bits wide as chosen by a parameter. The frames carry packets laid end to end with no padding. Each packet is a 20-bit header followed by a payload, and a packet may start anywhere inside one frame and finish in a later one. The block collects the bits in a residue buffer and tracks how many bits it holds with a bit-granular fill count. As soon as a whole packet is at the bottom of that buffer, the block emits it on a valid/ready output.

The header holds a 12-bit crossing identifier followed by an 8-bit length count. The payload size in bits is this count multiplied by the configured length unit. Only units of 4 and 8 are accepted. Any other unit, including 1, raises a configuration error, and while that error is present the block stops accepting and decoding.

Top module: `frame_pkt_unpacker`

## Requirements
- R1: After a synchronous reset, out_valid is 0, the fill count is 0 and, with a legal unit, in_ready is 1.
- R2: Stream order runs from bit 0 of a frame upward, then into the next frame. Of each header, the first 12 stream bits are out_bcid, with its LSB first.
- R3: The 8 header bits after the identifier form the length count, LSB first. out_len equals that count times len_unit, in bits.
- R4: The payload is right-aligned on out_data: the first payload bit appears on out_data[0], and every bit at position out_len or above is 0.
- R5: Packets that cross frame boundaries are rebuilt without gaps, and they leave the block in the order they arrived.
- R6: A length count of 0 gives a header-only packet, with out_valid 1, out_len 0 and out_data 0.
- R7: A len_unit other than 4 or 8 sets cfg_err to 1, holds in_ready at 0 and produces no new output packet.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_bcid, out_len and out_data stay unchanged.
- R9: in_ready falls to 0 before the residue buffer could overflow. No accepted frame bit is lost, and the fill count never exceeds the buffer depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| len_unit | input | 4 | Bits per length-count step (4 or 8 legal) |
| in_frame | input | FRAME_W | Link frame, bit 0 first in stream order |
| in_valid | input | 1 | in_frame holds a frame |
| in_ready | output | 1 | Block accepts a frame this cycle |
| out_valid | output | 1 | A decoded packet is presented |
| out_ready | input | 1 | Consumer takes the packet |
| out_bcid | output | 12 | Crossing identifier of the packet |
| out_len | output | 11 | Payload length in bits |
| out_data | output | 2040 | Payload, right-aligned, zero above out_len |
| cfg_err | output | 1 | len_unit is illegal |

## Verification
Appending a new frame above the current fill and shifting a finished packet out of the bottom of the residue can both happen in the same clock cycle. In that case the new frame must be placed at the fill level that remains after the removal. The bench provokes this by offering frames every cycle while out_ready follows a pattern that is sometimes high and sometimes low, and by holding out_ready low long enough to fill the buffer and then releasing it. It judges the result by comparing every packet field and every payload bit against a stream the bench builds itself.

// File: rtl/frame_pkt_unpacker.sv
module frame_pkt_unpacker #(
  parameter int FRAME_W  = 80,
  parameter int BCID_W   = 12,
  parameter int LEN_W    = 8,
  parameter int UNIT_MAX = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [3:0]           len_unit,
  input  logic [FRAME_W-1:0]   in_frame,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [BCID_W-1:0]    out_bcid,
  output logic [$clog2(((1<<LEN_W)-1)*UNIT_MAX+1)-1:0] out_len,
  output logic [((1<<LEN_W)-1)*UNIT_MAX-1:0]           out_data,
  output logic                 cfg_err
);
  localparam int HDR_W   = BCID_W + LEN_W;
  localparam int PAY_MAX = ((1 << LEN_W) - 1) * UNIT_MAX;
  localparam int PLEN_W  = $clog2(PAY_MAX + 1);
  localparam int DEPTH   = 2 * FRAME_W + HDR_W + PAY_MAX;
  localparam int CNT_W   = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] resid;
  logic [CNT_W-1:0] fill;

  assign cfg_err = !(len_unit == 4'd4 || len_unit == 4'd8);

  wire [LEN_W-1:0]  hdr_len  = resid[BCID_W +: LEN_W];
  wire [PLEN_W-1:0] pay_bits = PLEN_W'(hdr_len) * PLEN_W'(len_unit);
  wire [CNT_W-1:0]  pkt_bits = CNT_W'(HDR_W) + CNT_W'(pay_bits);

  wire pop  = !cfg_err && (fill >= pkt_bits) && (!out_valid || out_ready);
  assign in_ready = !cfg_err && (fill <= CNT_W'(DEPTH - FRAME_W));
  wire push = in_valid && in_ready;

  wire [DEPTH-1:0] kept   = pop ? (resid >> pkt_bits) : resid;
  wire [CNT_W-1:0] fill_k = pop ? (fill - pkt_bits) : fill;

  wire [PAY_MAX-1:0] pay_mask = ~({PAY_MAX{1'b1}} << pay_bits);
  wire [PAY_MAX-1:0] pay_raw  = PAY_MAX'(resid >> HDR_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      resid     <= '0;
      fill      <= '0;
      out_valid <= 1'b0;
      out_bcid  <= '0;
      out_len   <= '0;
      out_data  <= '0;
    end else begin
      if (push) begin
        resid <= kept | (DEPTH'(in_frame) << fill_k);
        fill  <= fill_k + CNT_W'(FRAME_W);
      end else begin
        resid <= kept;
        fill  <= fill_k;
      end
      if (pop) begin
        out_valid <= 1'b1;
        out_bcid  <= resid[BCID_W-1:0];
        out_len   <= pay_bits;
        out_data  <= pay_raw & pay_mask;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/frame_pkt_unpacker_chk.sv
module frame_pkt_unpacker_chk #(
  parameter int FRAME_W  = 80,
  parameter int BCID_W   = 12,
  parameter int LEN_W    = 8,
  parameter int UNIT_MAX = 8
) (
  input logic clk,
  input logic rst,
  input logic cfg_err,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic [BCID_W-1:0] out_bcid,
  input logic [$clog2(((1<<LEN_W)-1)*UNIT_MAX+1)-1:0] out_len,
  input logic [((1<<LEN_W)-1)*UNIT_MAX-1:0] out_data,
  input logic [$clog2(2*FRAME_W+BCID_W+LEN_W+((1<<LEN_W)-1)*UNIT_MAX+1)-1:0] fill
);
  localparam int PAY_MAX = ((1 << LEN_W) - 1) * UNIT_MAX;
  localparam int DEPTH   = 2 * FRAME_W + BCID_W + LEN_W + PAY_MAX;

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !out_valid && fill == 0); // R1
  AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_len <= PAY_MAX); // R3
  AST_DATA_MASK: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data >> out_len) == '0); // R4
  AST_EMPTY_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_len == 0 |-> out_data == '0); // R6
  AST_CFG_BLOCK: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !in_ready); // R7
  AST_CFG_NO_OUT: assert property (@(posedge clk) disable iff (rst)
    cfg_err && !out_valid |=> !out_valid); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_bcid) && $stable(out_len)
      && $stable(out_data)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fill <= DEPTH); // R9
endmodule

bind frame_pkt_unpacker frame_pkt_unpacker_chk #(
  .FRAME_W(FRAME_W), .BCID_W(BCID_W), .LEN_W(LEN_W), .UNIT_MAX(UNIT_MAX)
) chk_i (
  .clk(clk), .rst(rst), .cfg_err(cfg_err), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_bcid(out_bcid),
  .out_len(out_len), .out_data(out_data), .fill(fill)
);

// File: tb/frame_pkt_unpacker_tb.sv
`timescale 1ns/1ps
module frame_pkt_unpacker_tb_top;
  localparam int FRAME_W = 80;
  localparam int PAY_MAX = 2040;
  localparam int NPKT    = 10;
  localparam logic [19:0] PKTS [NPKT] = '{
    {12'h064, 8'h0A}, {12'h065, 8'h00}, {12'h066, 8'hFF}, {12'h067, 8'h01},
    {12'h068, 8'h00}, {12'h069, 8'h13}, {12'h06A, 8'h05}, {12'hFFF, 8'hFF},
    {12'h06C, 8'h00}, {12'h06D, 8'h3C}};

  logic clk = 0, rst = 1;
  logic [3:0] len_unit = 4'd4;
  logic [FRAME_W-1:0] in_frame = '0;
  logic in_valid = 0, out_ready = 0;
  logic in_ready, out_valid, cfg_err;
  logic [11:0] out_bcid;
  logic [10:0] out_len;
  logic [PAY_MAX-1:0] out_data;

  frame_pkt_unpacker #(.FRAME_W(FRAME_W)) dut_i (
    .clk(clk), .rst(rst), .len_unit(len_unit), .in_frame(in_frame),
    .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_bcid(out_bcid), .out_len(out_len),
    .out_data(out_data), .cfg_err(cfg_err));

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit sbits [0:8191];
  int nbits, nframes;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  function automatic bit pbit(int bc, int i);
    return bit'(((bc * 37 + i * 11 + (i >> 3)) >> 1) & 1);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; in_valid = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic build(int unit);
    nbits = 0;
    for (int p = 0; p < NPKT; p++) begin
      for (int b = 0; b < 12; b++) sbits[nbits++] = PKTS[p][8 + b];
      for (int b = 0; b < 8; b++)  sbits[nbits++] = PKTS[p][b];
      for (int i = 0; i < int'(PKTS[p][7:0]) * unit; i++)
        sbits[nbits++] = pbit(int'(PKTS[p][19:8]), i);
    end
    nframes = (nbits + FRAME_W - 1) / FRAME_W;
    for (int b = nbits; b < nframes * FRAME_W; b++) sbits[b] = 0;
  endtask

  // mode 0: always ready, 1: ready 2 of 3 cycles, 2: blocked 300 cycles then ready
  task automatic run(int unit, int mode);
    int fi = 0, pk = 0, t = 0;
    bit hold = 0, saw_full = 0;
    logic [11:0] hb; logic [10:0] hl; logic [PAY_MAX-1:0] hd;
    logic [PAY_MAX-1:0] exp;
    int elen;
    len_unit = 4'(unit);
    do_reset();
    build(unit);
    while (pk < NPKT && t < 6000) begin
      @(negedge clk);
      t++;
      if (hold)
        chk(out_valid && out_bcid == hb && out_len == hl && out_data == hd,
            "R8", "stalled packet changed", longint'(out_bcid), longint'(hb));
      out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? (t % 3 != 0) : (t > 300);
      if (mode == 2 && t <= 300 && !in_ready) saw_full = 1;
      if (fi < nframes) begin
        in_valid = 1;
        for (int b = 0; b < FRAME_W; b++) in_frame[b] = sbits[fi * FRAME_W + b];
        if (in_ready) fi++;
      end else in_valid = 0;
      hold = out_valid && !out_ready;
      hb = out_bcid; hl = out_len; hd = out_data;
      if (out_valid && out_ready) begin
        elen = int'(PKTS[pk][7:0]) * unit;
        exp = '0;
        for (int i = 0; i < elen; i++) exp[i] = pbit(int'(PKTS[pk][19:8]), i);
        chk(out_bcid == PKTS[pk][19:8], "R2/R5", "bcid", longint'(out_bcid),
            longint'(PKTS[pk][19:8]));
        chk(int'(out_len) == elen, "R3", "payload length", longint'(out_len), longint'(elen));
        chk(out_data == exp, "R4", "payload bits", longint'(out_data[63:0]),
            longint'(exp[63:0]));
        if (elen == 0)
          chk(out_data == '0, "R6", "header-only payload", longint'(out_data[63:0]), 0);
        pk++;
      end
    end
    in_valid = 0;
    chk(pk == NPKT, "R5", "packets delivered", longint'(pk), longint'(NPKT));
    if (mode == 2) chk(saw_full, "R9", "in_ready dropped when full", 0, 1);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    chk(!out_valid, "R1", "out_valid after reset", longint'(out_valid), 0);
    chk(in_ready, "R1", "in_ready after reset", longint'(in_ready), 1);
    chk(!cfg_err, "R7", "cfg_err with unit 4", longint'(cfg_err), 0);

    run(4, 0);
    run(8, 0);
    run(4, 1);
    run(8, 1);
    run(8, 2);

    foreach (PKTS[k]) begin end
    for (int u = 0; u < 4; u++) begin
      len_unit = 4'(u == 3 ? 9 : u);
      do_reset();
      build(4);
      out_ready = 1;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        in_valid = 1;
        for (int b = 0; b < FRAME_W; b++) in_frame[b] = sbits[(c % nframes) * FRAME_W + b];
        if (out_valid) chk(0, "R7", "output under bad unit", 1, 0);
      end
      chk(cfg_err, "R7", "cfg_err raised", longint'(cfg_err), 1);
      chk(!in_ready, "R7", "in_ready blocked", longint'(in_ready), 0);
      in_valid = 0;
    end

    len_unit = 4'd4;
    do_reset();
    build(4);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      in_valid = 1;
      for (int b = 0; b < FRAME_W; b++) in_frame[b] = sbits[c * FRAME_W + b];
    end
    @(negedge clk); in_valid = 0;
    chk(out_valid, "R8", "packet waits while out_ready low", longint'(out_valid), 1);
    do_reset();
    @(negedge clk);
    chk(!out_valid, "R1", "out_valid after mid-stream reset", longint'(out_valid), 0);
    chk(in_ready, "R1", "in_ready after mid-stream reset", longint'(in_ready), 1);
    run(4, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule